// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block sits between an interrupt source unit and one processor. It holds a single presentation slot: a 32-bit status word whose top byte is the processor's current priority and whose low 24 bits name the source now waiting for service. A separate pending-priority byte records how urgent that source is. An 8-bit inter-processor request register lets software post an interrupt from another processor at a chosen priority. Lower priority values are more favoured throughout.

The source unit offers interrupts one at a time. Each offer is either latched into the slot, which raises the level interrupt line to the processor, or bounced back with a reject pulse so that the source unit can retry it later. A more favoured offer pushes out a less favoured one, and the displaced source is rejected. Software acts on the block through four operations: set processor priority, set inter-processor request priority, accept (read and acknowledge), and end-of-interrupt. When the processor priority is relaxed and the slot is empty, the block asks the source unit to resend everything it has rejected.

Top module: `irq_present_ctrl`

## Requirements
- R1: After reset the interrupt line is low, no pulse is active, the status word reads zero (priority 0, no source) and the inter-processor request priority is 0xFF, so relaxing the priority to 0xFF presents nothing.
- R2: An offer (source number never zero) is rejected when its priority is greater than or equal to the processor priority, or when a source is pending whose pending priority is less than or equal to the offered one; the reject pulse carries the offered source number.
- R3: An offer that is not rejected is latched with its priority and the interrupt line rises; if a source was already pending, that old source is rejected in the same cycle.
- R4: Accept (op code 2) returns the status word {priority[31:24], source[23:0]} as it stood, lowers the line, loads the processor priority from the pending priority and clears the source.
- R5: Set priority (op code 0, value in data[7:0]) to a more favoured value clears the slot, lowers the line and rejects the pending source, but only if a source is pending and the new value is less than or equal to the pending priority.
- R6: Set priority to an equal or less favoured value with the slot empty runs the resend sequence: if the request priority is below the new processor priority the inter-processor source is presented first, then a resend pulse is issued.
- R7: Set request priority (op code 1, value in data[7:0]) stores the value; if it is below the processor priority, source number 2 is presented at that priority unless the pending priority is already less than or equal to it, evicting any less favoured pending source with a reject.
- R8: End-of-interrupt (op code 3) emits an EOI pulse carrying data[23:0], loads the processor priority from data[31:24], and runs the resend sequence if the slot is empty.
- R9: An offer in the same cycle as an operation is dropped: the operation alone acts and no reject is issued for the offer.
- R10: Every output is registered and changes on the clock edge that samples the input; reject, resend, EOI and response pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offer_valid_i | input | 1 | Source unit offers an interrupt this cycle |
| offer_src_i | input | 24 | Offered source number |
| offer_prio_i | input | 8 | Offered priority |
| op_valid_i | input | 1 | Register operation this cycle |
| op_kind_i | input | 2 | 0 set priority, 1 set request priority, 2 accept, 3 end-of-interrupt |
| op_data_i | input | 32 | Operation data word |
| irq_o | output | 1 | Level interrupt line to the processor |
| resp_valid_o | output | 1 | Accept response valid |
| resp_word_o | output | 32 | Status word returned by accept |
| reject_o | output | 1 | Reject pulse to the source unit |
| reject_src_o | output | 24 | Rejected source number |
| resend_o | output | 1 | Resend request pulse to the source unit |
| eoi_o | output | 1 | End-of-interrupt pulse to the source unit |
| eoi_src_o | output | 24 | Source number being completed |

## Verification
Offers are tried below, equal to and above the processor priority, and with the slot empty, held by a less favoured source and held by an equal one, which separates plain rejection from eviction. Priority writes are tried in both directions with and without a pending source, so that clearing, no action and the resend sequence with and without an inter-processor presentation are each seen. Request writes are tried against an empty slot, a more favoured pending source and an evictable one, and an offer is placed on the same cycle as an operation. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned DEF_PRIO_W  = 8;
  localparam int unsigned DEF_SRC_W   = 24;
  localparam int unsigned DEF_IPI_SRC = 2;

  typedef enum logic [1:0] {
    OP_SET_PRIO = 2'd0,
    OP_SET_IPI  = 2'd1,
    OP_ACCEPT   = 2'd2,
    OP_EOI      = 2'd3
  } op_e;
endpackage

// File: rtl/ipc_offer_gate.sv
module ipc_offer_gate #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned SRC_W  = 24
) (
  input  logic [PRIO_W-1:0] cppr_i,
  input  logic [SRC_W-1:0]  xisr_i,
  input  logic [PRIO_W-1:0] pend_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              take_o,
  output logic              evict_o
);
  logic busy;
  logic blocked;

  assign busy    = |xisr_i;
  assign blocked = (prio_i >= cppr_i) || (busy && (pend_i <= prio_i));
  assign take_o  = !blocked;
  assign evict_o = !blocked && busy;
endmodule

// File: rtl/ipc_ipi_gate.sv
module ipc_ipi_gate #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned SRC_W  = 24
) (
  input  logic [PRIO_W-1:0] mfrr_i,
  input  logic [PRIO_W-1:0] cppr_i,
  input  logic [SRC_W-1:0]  xisr_i,
  input  logic [PRIO_W-1:0] pend_i,
  output logic              take_o,
  output logic              evict_o
);
  logic busy;
  logic want;
  logic held;

  assign busy    = |xisr_i;
  assign want    = mfrr_i < cppr_i;
  // a pending source at least as favoured keeps the slot
  assign held    = busy && (pend_i <= mfrr_i);
  assign take_o  = want && !held;
  assign evict_o = want && !held && busy;
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl #(
  parameter int unsigned PRIO_W  = ipc_pkg::DEF_PRIO_W,
  parameter int unsigned SRC_W   = ipc_pkg::DEF_SRC_W,
  parameter int unsigned IPI_SRC = ipc_pkg::DEF_IPI_SRC,
  localparam int unsigned WORD_W = PRIO_W + SRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              offer_valid_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  input  logic              op_valid_i,
  input  logic [1:0]        op_kind_i,
  input  logic [WORD_W-1:0] op_data_i,
  output logic              irq_o,
  output logic              resp_valid_o,
  output logic [WORD_W-1:0] resp_word_o,
  output logic              reject_o,
  output logic [SRC_W-1:0]  reject_src_o,
  output logic              resend_o,
  output logic              eoi_o,
  output logic [SRC_W-1:0]  eoi_src_o
);
  import ipc_pkg::*;

  localparam logic [SRC_W-1:0]  IPI_NUM  = SRC_W'(IPI_SRC);
  localparam logic [PRIO_W-1:0] PRIO_MIN = '1;

  // presentation state
  logic [PRIO_W-1:0] cppr_q, cppr_d;
  logic [SRC_W-1:0]  xisr_q, xisr_d;
  logic [PRIO_W-1:0] pend_q, pend_d;
  logic [PRIO_W-1:0] mfrr_q, mfrr_d;
  logic              irq_q,  irq_d;

  // outbound pulses
  logic              rej_q, rej_d;
  logic [SRC_W-1:0]  rej_src_q, rej_src_d;
  logic              rsnd_q, rsnd_d;
  logic              eoi_q, eoi_d;
  logic [SRC_W-1:0]  eoi_src_q, eoi_src_d;
  logic              rv_q, rv_d;
  logic [WORD_W-1:0] rw_q, rw_d;

  op_e               op_kind;
  logic [PRIO_W-1:0] op_prio;
  logic [PRIO_W-1:0] eoi_prio;
  logic [PRIO_W-1:0] rs_cppr;
  logic              ofr_take, ofr_evict;
  logic              ipw_take, ipw_evict;
  logic              ipr_take, ipr_evict;

  assign op_kind  = op_e'(op_kind_i);
  assign op_prio  = op_data_i[PRIO_W-1:0];
  assign eoi_prio = op_data_i[WORD_W-1:SRC_W];
  // priority the resend sequence compares against
  assign rs_cppr  = (op_kind == OP_EOI) ? eoi_prio : op_prio;

  ipc_offer_gate #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_offer_gate (
    .cppr_i  (cppr_q),
    .xisr_i  (xisr_q),
    .pend_i  (pend_q),
    .prio_i  (offer_prio_i),
    .take_o  (ofr_take),
    .evict_o (ofr_evict)
  );

  // request-register write path
  ipc_ipi_gate #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_ipi_wr_gate (
    .mfrr_i  (op_prio),
    .cppr_i  (cppr_q),
    .xisr_i  (xisr_q),
    .pend_i  (pend_q),
    .take_o  (ipw_take),
    .evict_o (ipw_evict)
  );

  // resend path: only entered with an empty slot
  ipc_ipi_gate #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_ipi_rs_gate (
    .mfrr_i  (mfrr_q),
    .cppr_i  (rs_cppr),
    .xisr_i  ('0),
    .pend_i  (pend_q),
    .take_o  (ipr_take),
    .evict_o (ipr_evict)
  );

  always_comb begin
    cppr_d    = cppr_q;
    xisr_d    = xisr_q;
    pend_d    = pend_q;
    mfrr_d    = mfrr_q;
    irq_d     = irq_q;
    rej_d     = 1'b0;
    rej_src_d = '0;
    rsnd_d    = 1'b0;
    eoi_d     = 1'b0;
    eoi_src_d = '0;
    rv_d      = 1'b0;
    rw_d      = '0;

    if (op_valid_i) begin
      unique case (op_kind)
        OP_SET_PRIO: begin
          cppr_d = op_prio;
          if (op_prio < cppr_q) begin
            if ((xisr_q != '0) && (op_prio <= pend_q)) begin
              xisr_d    = '0;
              irq_d     = 1'b0;
              rej_d     = 1'b1;
              rej_src_d = xisr_q;
            end
          end else if (xisr_q == '0) begin
            rsnd_d = 1'b1;
            if (ipr_take) begin
              xisr_d = IPI_NUM;
              pend_d = mfrr_q;
              irq_d  = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          mfrr_d = op_prio;
          if (ipw_take) begin
            xisr_d = IPI_NUM;
            pend_d = op_prio;
            irq_d  = 1'b1;
            if (ipw_evict) begin
              rej_d     = 1'b1;
              rej_src_d = xisr_q;
            end
          end
        end
        OP_ACCEPT: begin
          rv_d   = 1'b1;
          rw_d   = {cppr_q, xisr_q};
          irq_d  = 1'b0;
          cppr_d = pend_q;
          xisr_d = '0;
        end
        OP_EOI: begin
          eoi_d     = 1'b1;
          eoi_src_d = op_data_i[SRC_W-1:0];
          cppr_d    = eoi_prio;
          if (xisr_q == '0) begin
            rsnd_d = 1'b1;
            if (ipr_take) begin
              xisr_d = IPI_NUM;
              pend_d = mfrr_q;
              irq_d  = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (offer_valid_i) begin
      if (ofr_take) begin
        xisr_d = offer_src_i;
        pend_d = offer_prio_i;
        irq_d  = 1'b1;
        if (ofr_evict) begin
          rej_d     = 1'b1;
          rej_src_d = xisr_q;
        end
      end else begin
        rej_d     = 1'b1;
        rej_src_d = offer_src_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cppr_q    <= '0;
      xisr_q    <= '0;
      pend_q    <= '0;
      mfrr_q    <= PRIO_MIN;
      irq_q     <= 1'b0;
      rej_q     <= 1'b0;
      rej_src_q <= '0;
      rsnd_q    <= 1'b0;
      eoi_q     <= 1'b0;
      eoi_src_q <= '0;
      rv_q      <= 1'b0;
      rw_q      <= '0;
    end else begin
      cppr_q    <= cppr_d;
      xisr_q    <= xisr_d;
      pend_q    <= pend_d;
      mfrr_q    <= mfrr_d;
      irq_q     <= irq_d;
      rej_q     <= rej_d;
      rej_src_q <= rej_src_d;
      rsnd_q    <= rsnd_d;
      eoi_q     <= eoi_d;
      eoi_src_q <= eoi_src_d;
      rv_q      <= rv_d;
      rw_q      <= rw_d;
    end
  end

  assign irq_o        = irq_q;
  assign resp_valid_o = rv_q;
  assign resp_word_o  = rw_q;
  assign reject_o     = rej_q;
  assign reject_src_o = rej_src_q;
  assign resend_o     = rsnd_q;
  assign eoi_o        = eoi_q;
  assign eoi_src_o    = eoi_src_q;

  logic unused_ok;
  assign unused_ok = ipr_evict;
endmodule

// File: rtl/irq_present_ctrl_chk.sv
module irq_present_ctrl_chk #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned SRC_W  = 24,
  localparam int unsigned WORD_W = PRIO_W + SRC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              offer_valid_i,
  input logic [SRC_W-1:0]  offer_src_i,
  input logic [PRIO_W-1:0] offer_prio_i,
  input logic              op_valid_i,
  input logic [1:0]        op_kind_i,
  input logic [WORD_W-1:0] op_data_i,
  input logic              irq_o,
  input logic              resp_valid_o,
  input logic              reject_o,
  input logic [SRC_W-1:0]  reject_src_o,
  input logic              resend_o,
  input logic              eoi_o,
  input logic [SRC_W-1:0]  eoi_src_o,
  input logic [PRIO_W-1:0] cppr_q,
  input logic [SRC_W-1:0]  xisr_q,
  input logic [PRIO_W-1:0] mfrr_q
);
  p_offer_low_rej_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offer_valid_i && !op_valid_i && (offer_prio_i >= cppr_q))
      |=> (reject_o && (reject_src_o == $past(offer_src_i))));

  p_irq_has_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (xisr_q != '0));

  p_accept_resp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_kind_i == 2'd2)) |=> (resp_valid_o && !irq_o && (xisr_q == '0)));

  p_prio_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_kind_i == 2'd0)) |=> (cppr_q == $past(op_data_i[PRIO_W-1:0])));

  p_resend_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resend_o |-> $past(op_valid_i && ((op_kind_i == 2'd0) || (op_kind_i == 2'd3))));

  p_ipi_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_kind_i == 2'd1)) |=> (mfrr_q == $past(op_data_i[PRIO_W-1:0])));

  p_eoi_fwd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_kind_i == 2'd3))
      |=> (eoi_o && (eoi_src_o == $past(op_data_i[SRC_W-1:0]))));

  p_no_offer_rej_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_kind_i[1]) |=> !reject_o);
endmodule

bind irq_present_ctrl irq_present_ctrl_chk #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .offer_valid_i (offer_valid_i),
  .offer_src_i   (offer_src_i),
  .offer_prio_i  (offer_prio_i),
  .op_valid_i    (op_valid_i),
  .op_kind_i     (op_kind_i),
  .op_data_i     (op_data_i),
  .irq_o         (irq_o),
  .resp_valid_o  (resp_valid_o),
  .reject_o      (reject_o),
  .reject_src_o  (reject_src_o),
  .resend_o      (resend_o),
  .eoi_o         (eoi_o),
  .eoi_src_o     (eoi_src_o),
  .cppr_q        (cppr_q),
  .xisr_q        (xisr_q),
  .mfrr_q        (mfrr_q)
);

// File: tb/irq_present_ctrl_tb_top.sv
`timescale 1ns/100ps
module irq_present_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_valid = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [31:0] op_data = '0;
  logic        irq, resp_valid, reject, resend, eoi;
  logic [31:0] resp_word;
  logic [23:0] reject_src, eoi_src;

  int checks = 0;
  int failures = 0;

  // reference model state
  int m_cppr = 0, m_xisr = 0, m_pend = 0, m_mfrr = 255;
  bit m_irq = 0;
  bit e_rej, e_rsnd, e_eoi, e_rv;
  int e_rej_src, e_eoi_src;
  logic [31:0] e_rw;

  always #2.5 clk = ~clk;

  irq_present_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .offer_valid_i(offer_valid), .offer_src_i(offer_src), .offer_prio_i(offer_prio),
    .op_valid_i(op_valid), .op_kind_i(op_kind), .op_data_i(op_data),
    .irq_o(irq), .resp_valid_o(resp_valid), .resp_word_o(resp_word),
    .reject_o(reject), .reject_src_o(reject_src), .resend_o(resend),
    .eoi_o(eoi), .eoi_src_o(eoi_src)
  );

  task automatic m_reject(input int src);
    e_rej = 1; e_rej_src = src;
  endtask

  task automatic m_check_ipi();
    if (m_xisr != 0 && m_pend <= m_mfrr) return;
    if (m_xisr != 0) m_reject(m_xisr);
    m_xisr = 2; m_pend = m_mfrr; m_irq = 1;
  endtask

  task automatic m_resend();
    if (m_mfrr < m_cppr) m_check_ipi();
    e_rsnd = 1;
  endtask

  task automatic show_summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // one clock: drive at negedge, predict, compare at the next negedge
  task automatic step(input bit ov, input int kind, input logic [31:0] data,
                      input bit fv, input int src, input int prio, input string tag);
    int np;
    op_valid = ov; op_kind = kind[1:0]; op_data = data;
    offer_valid = fv; offer_src = src[23:0]; offer_prio = prio[7:0];
    e_rej = 0; e_rsnd = 0; e_eoi = 0; e_rv = 0;
    e_rej_src = 0; e_eoi_src = 0; e_rw = '0;
    if (ov) begin
      case (kind)
        0: begin
          np = int'(data[7:0]);
          if (np < m_cppr) begin
            m_cppr = np;
            if (m_xisr != 0 && np <= m_pend) begin
              m_reject(m_xisr); m_xisr = 0; m_irq = 0;
            end
          end else begin
            m_cppr = np;
            if (m_xisr == 0) m_resend();
          end
        end
        1: begin
          m_mfrr = int'(data[7:0]);
          if (m_mfrr < m_cppr) m_check_ipi();
        end
        2: begin
          e_rv = 1; e_rw = {m_cppr[7:0], m_xisr[23:0]};
          m_irq = 0; m_cppr = m_pend; m_xisr = 0;
        end
        default: begin
          e_eoi = 1; e_eoi_src = int'(data[23:0]);
          m_cppr = int'(data[31:24]);
          if (m_xisr == 0) m_resend();
        end
      endcase
    end else if (fv) begin
      if (prio >= m_cppr || (m_xisr != 0 && m_pend <= prio)) m_reject(src);
      else begin
        if (m_xisr != 0) m_reject(m_xisr);
        m_xisr = src; m_pend = prio; m_irq = 1;
      end
    end
    @(negedge clk);
    checks++;
    if (irq !== m_irq || reject !== e_rej || resend !== e_rsnd || eoi !== e_eoi ||
        resp_valid !== e_rv ||
        (e_rej && reject_src !== e_rej_src[23:0]) ||
        (e_eoi && eoi_src !== e_eoi_src[23:0]) ||
        (e_rv && resp_word !== e_rw)) begin
      failures++;
      $display("FAIL %s irq=%0b/%0b rej=%0b/%0b rsrc=%0h/%0h rsnd=%0b/%0b eoi=%0b/%0b esrc=%0h/%0h rv=%0b/%0b rw=%08h/%08h (actual/expected)",
               tag, irq, m_irq, reject, e_rej, reject_src, e_rej_src, resend, e_rsnd,
               eoi, e_eoi, eoi_src, e_eoi_src, resp_valid, e_rv, resp_word, e_rw);
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 32'h0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    show_summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    step(1, 2, 32'h0, 0, 0, 0, "R1 accept after reset");
    step(0, 0, 32'h0, 1, 100, 5, "R2 offer vs priority 0");
    step(1, 0, 32'h0000_00FF, 0, 0, 0, "R6 relax to FF, request FF");
    idle("R10 resend single pulse");
    step(0, 0, 32'h0, 1, 100, 10, "R3 latch into empty slot");
    step(0, 0, 32'h0, 1, 200, 10, "R2 equal pending priority");
    step(0, 0, 32'h0, 1, 300, 4, "R3 evict less favoured");
    idle("R10 reject single pulse");
    step(1, 2, 32'h0, 0, 0, 0, "R4 accept returns word");
    step(0, 0, 32'h0, 1, 55, 4, "R2 equal to processor priority");
    step(0, 0, 32'h0, 1, 56, 3, "R3 latch after accept");
    step(1, 0, 32'h0000_0003, 0, 0, 0, "R5 tighten clears slot");
    step(1, 0, 32'h0000_0002, 1, 77, 1, "R9 offer with operation dropped");
    idle("R9 no late action");
    step(1, 3, 32'h0800_0123, 0, 0, 0, "R8 eoi forwards and resends");
    step(1, 1, 32'h0000_0005, 0, 0, 0, "R7 request presented");
    step(0, 0, 32'h0, 1, 9, 6, "R2 pending more favoured");
    step(0, 0, 32'h0, 1, 9, 1, "R3 evict request source");
    step(1, 1, 32'h0000_0003, 0, 0, 0, "R7 request held off");
    step(1, 2, 32'h0, 0, 0, 0, "R4 accept source 9");
    step(1, 3, 32'h0A00_0009, 0, 0, 0, "R6 eoi resend presents request");
    step(1, 0, 32'h0000_0002, 0, 0, 0, "R5 tighten rejects request source");
    step(1, 0, 32'h0000_0006, 0, 0, 0, "R6 relax presents request");
    step(1, 1, 32'h0000_0004, 0, 0, 0, "R7 no change when pending favoured");
    step(1, 0, 32'h0000_00FF, 0, 0, 0, "R6 relax with slot full");
    step(1, 2, 32'h0, 0, 0, 0, "R4 accept request source");
    step(1, 0, 32'h0000_0001, 0, 0, 0, "R5 tighten with empty slot");
    step(1, 1, 32'h0000_0000, 0, 0, 0, "R7 request at priority 0");
    step(1, 0, 32'h0000_0000, 0, 0, 0, "R5 tighten to 0 rejects request");
    step(1, 1, 32'h0000_00FF, 0, 0, 0, "R7 request cleared");
    step(1, 3, 32'h3000_0002, 0, 0, 0, "R8 eoi with no request");
    idle("R10 final idle");
    show_summary();
    $finish;
  end
endmodule